// File: doc/BRIEF.md
# Single-Channel DMA Request and Transfer Controller

This block is one DMA channel. Software configures it through a small register port. A 4-bit cause code and an expansion bit choose which of sixteen sources may raise a request. The sources are fourteen peripheral strobes, a software trigger and an external interrupt pin. Two alternate strobes and a both-edges pin mode take over three of the codes when the expansion bit is set. A request from the chosen source latches a pending flag.

While the channel is enabled, each pending request is serviced as one read from the source address followed by one write to the destination address. The bus master port carries these accesses. Each address either stays fixed or steps forward by the transfer unit, which is 1 byte or 2 bytes. A transfer counter tracks the remaining transfers. At terminal count the channel either disables itself (single mode) or reloads its count and start addresses (repeat mode).

Register map, with 16-bit data and a 3-bit address:
- 0: cause. Bits 3:0 hold the code, bit 4 is the expansion bit, and bit 5 is the write-1 software trigger.
- 1: control. Bit 0 selects an 8-bit unit, bit 1 selects repeat mode, bit 2 is the pending flag, bit 3 is the enable, bit 4 sets the source forward and bit 5 sets the destination forward.
- 2, 3 and 4: source reload, destination reload and count reload. A write to any of them also loads the matching live value.
- 5, 6 and 7: live source, live destination and live count (read only).

Read data is registered and is valid in the cycle after the address is presented.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, registers 0 and 1 read 0 and the bus port is idle (bus_valid low).
- R2: With the expansion bit 0, a code from 2 to 15 sets the pending flag (control bit 2) on a strobe of periph_req[code]. Strobes on every other peripheral input and on alt_req leave the flag at 0.
- R3: Code 0 sets the pending flag on a falling edge of ext_pin, after a two-flop synchronizer. A rising edge does not set it.
- R4: With the expansion bit 1, codes 5 and 6 take alt_req[0] and alt_req[1] instead of periph_req[5] and periph_req[6]. Code 7 responds to both edges of ext_pin.
- R5: Writing register 0 with bit 5 set raises a request only when the written code is 1. Bit 5 always reads back 0.
- R6: Writing 0 to control bit 2 clears the pending flag. Writing 1 to it leaves the flag unchanged.
- R7: A control write that sets both bits 4 and 5 keeps the previous direction bits. The other fields of that write still take effect. The two direction bits are never both 1.
- R8: Unassigned bits (register 0 bits 15:6, register 1 bits 15:6) read 0, and writes to them are ignored.
- R9: A transfer starts only when the pending flag and the enable bit are both 1. A request that arrives while the channel is disabled is kept as pending. The flag clears when the bus accepts the source read.
- R10: A transfer reads the live source address and then writes the read data to the live destination address. With an 8-bit unit, bus_byte is 1 and the upper write byte is 0. A forward address then advances by 1 (8-bit unit) or 2 (16-bit unit); a fixed address stays put.
- R11: In single mode, the enable bit clears after the transfer that brings the live count to 0.
- R12: In repeat mode, the transfer that reaches terminal count reloads the live count and both live addresses from the reload registers, and the channel stays enabled.
- R13: While bus_valid is high and bus_ack is low, bus_valid, bus_we and bus_addr hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Registered read data for the previous cycle's address |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| periph_req | input | 14 | Peripheral request strobes, indexed 15 down to 2 by cause code |
| alt_req | input | 2 | Alternate strobes for expanded codes 5 and 6 |
| bus_valid | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_byte | output | 1 | 1 for an 8-bit access |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, taken with bus_ack |
| bus_ack | input | 1 | Access completes in the cycle it is high |

## Verification
The hardest situation to reach is a request that sits pending across a period when the channel is disabled, followed by a repeat-mode wrap in which the live addresses and count snap back to their reload values mid-stream. The stimulus first drains a single-mode run to terminal count. It then strobes the selected source while the channel is off, and checks that no bus access appears. Finally it re-enables the channel in repeat mode with a write that also carries a 1 into the pending bit, so the held request must start a transfer at once. Bus acknowledges arrive after random delays throughout, which stretches every access phase.

// File: rtl/dma_chan_pkg.sv
`timescale 1ns/1ps
package dma_chan_pkg;
  localparam int CAUSE_W = 4;
  localparam int NUM_SRC = 1 << CAUSE_W;
  localparam int REG_W   = 16;

  localparam logic [2:0] RA_CAUSE   = 3'd0;
  localparam logic [2:0] RA_CTRL    = 3'd1;
  localparam logic [2:0] RA_SRC     = 3'd2;
  localparam logic [2:0] RA_DST     = 3'd3;
  localparam logic [2:0] RA_CNT     = 3'd4;
  localparam logic [2:0] RA_CUR_SRC = 3'd5;
  localparam logic [2:0] RA_CUR_DST = 3'd6;
  localparam logic [2:0] RA_CUR_CNT = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_state_t;

  // Packed LSB-last: unit8 is bit 0, dst_fwd is bit 5.
  typedef struct packed {
    logic dst_fwd;
    logic src_fwd;
    logic enable;
    logic pending;
    logic rpt;
    logic unit8;
  } ctrl_t;
endpackage

// File: rtl/dma_req_select.sv
`timescale 1ns/1ps
module dma_req_select
  import dma_chan_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ext_pin,
  input  logic [CAUSE_W-1:0] cause,
  input  logic               expand,
  input  logic               soft_trig,
  input  logic [NUM_SRC-1:2] periph_req,
  input  logic [1:0]         alt_req,
  output logic               req_hit
);
  localparam int SYNC_LEN = 3;

  logic [SYNC_LEN-1:0] pin_sh;
  logic                pin_fall, pin_both;
  logic [NUM_SRC-1:0]  src_vec;

  // Two synchronizer flops plus one history flop; idle level is high.
  always_ff @(posedge clk) begin
    if (rst) pin_sh <= '1;
    else     pin_sh <= {pin_sh[SYNC_LEN-2:0], ext_pin};
  end

  assign pin_fall = pin_sh[2] & ~pin_sh[1];
  assign pin_both = pin_sh[2] ^ pin_sh[1];

  always_comb begin
    src_vec    = '0;
    src_vec[0] = pin_fall;
    src_vec[1] = soft_trig;
    for (int k = 2; k < NUM_SRC; k++) src_vec[k] = periph_req[k];
    if (expand) begin
      src_vec[5] = alt_req[0];
      src_vec[6] = alt_req[1];
      src_vec[7] = pin_both;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) req_hit <= 1'b0;
    else     req_hit <= src_vec[cause];
  end
endmodule

// File: rtl/dma_xfer_engine.sv
`timescale 1ns/1ps
module dma_xfer_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              unit8,
  input  logic              rpt,
  input  logic              src_fwd,
  input  logic              dst_fwd,
  input  logic              ld_src,
  input  logic              ld_dst,
  input  logic              ld_cnt,
  input  logic [ADDR_W-1:0] ld_addr_val,
  input  logic [CNT_W-1:0]  ld_cnt_val,
  input  logic [ADDR_W-1:0] rl_src,
  input  logic [ADDR_W-1:0] rl_dst,
  input  logic [CNT_W-1:0]  rl_cnt,
  input  logic              bus_ack,
  input  logic [15:0]       bus_rdata,
  output logic              bus_valid,
  output logic              bus_we,
  output logic              bus_byte,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  output logic              accept,
  output logic              term_single,
  output logic              idle,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  cur_cnt
);
  xfer_state_t      state;
  logic             wr_done, last;
  logic [ADDR_W-1:0] step;

  assign idle        = (state == ST_IDLE);
  assign accept      = (state == ST_RD) && bus_ack;
  assign wr_done     = (state == ST_WR) && bus_ack;
  assign last        = (cur_cnt == CNT_W'(1));
  assign term_single = wr_done && last && !rpt;
  assign step        = bus_byte ? ADDR_W'(1) : ADDR_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_valid <= 1'b0;
      bus_we    <= 1'b0;
      bus_byte  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      cur_src   <= '0;
      cur_dst   <= '0;
      cur_cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state     <= ST_RD;
          bus_valid <= 1'b1;
          bus_we    <= 1'b0;
          bus_byte  <= unit8;
          bus_addr  <= cur_src;
        end
        ST_RD: if (bus_ack) begin
          state     <= ST_WR;
          bus_we    <= 1'b1;
          bus_addr  <= cur_dst;
          bus_wdata <= bus_byte ? {8'h00, bus_rdata[7:0]} : bus_rdata;
        end
        ST_WR: if (bus_ack) begin
          state     <= ST_IDLE;
          bus_valid <= 1'b0;
          bus_we    <= 1'b0;
          if (last && rpt) begin
            cur_src <= rl_src;
            cur_dst <= rl_dst;
            cur_cnt <= rl_cnt;
          end else begin
            if (src_fwd) cur_src <= cur_src + step;
            if (dst_fwd) cur_dst <= cur_dst + step;
            cur_cnt <= cur_cnt - CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (ld_src) cur_src <= ld_addr_val;
      if (ld_dst) cur_dst <= ld_addr_val;
      if (ld_cnt) cur_cnt <= ld_cnt_val;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
`timescale 1ns/1ps
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_we,
  input  logic [2:0]               reg_addr,
  input  logic [REG_W-1:0]         reg_wdata,
  output logic [REG_W-1:0]         reg_rdata,
  input  logic                     ext_pin,
  input  logic [NUM_SRC-1:2]       periph_req,
  input  logic [1:0]               alt_req,
  output logic                     bus_valid,
  output logic                     bus_we,
  output logic                     bus_byte,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [15:0]              bus_wdata,
  input  logic [15:0]              bus_rdata,
  input  logic                     bus_ack
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [CAUSE_W-1:0] cause_q;
  logic               expand_q;
  ctrl_t              ctrl_q;
  logic [ADDR_W-1:0]  rl_src, rl_dst, cur_src, cur_dst;
  logic [CNT_W-1:0]   rl_cnt, cur_cnt;
  logic               soft_q, req_hit, accept, term_single, eng_idle, start;
  logic               wr_cause, wr_ctrl, wr_src, wr_dst, wr_cnt, both_fwd;

  assign wr_cause = reg_we && (reg_addr == RA_CAUSE);
  assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
  assign wr_src   = reg_we && (reg_addr == RA_SRC);
  assign wr_dst   = reg_we && (reg_addr == RA_DST);
  assign wr_cnt   = reg_we && (reg_addr == RA_CNT);
  assign both_fwd = reg_wdata[4] && reg_wdata[5];
  assign start    = ctrl_q.pending && ctrl_q.enable && eng_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q  <= '0;
      expand_q <= 1'b0;
      soft_q   <= 1'b0;
      rl_src   <= '0;
      rl_dst   <= '0;
      rl_cnt   <= '0;
    end else begin
      soft_q <= wr_cause && reg_wdata[5];
      if (wr_cause) begin
        cause_q  <= reg_wdata[CAUSE_W-1:0];
        expand_q <= reg_wdata[4];
      end
      if (wr_src) rl_src <= reg_wdata[ADDR_W-1:0];
      if (wr_dst) rl_dst <= reg_wdata[ADDR_W-1:0];
      if (wr_cnt) rl_cnt <= reg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.unit8  <= reg_wdata[0];
        ctrl_q.rpt    <= reg_wdata[1];
        ctrl_q.enable <= reg_wdata[3];
        if (!both_fwd) begin
          ctrl_q.src_fwd <= reg_wdata[4];
          ctrl_q.dst_fwd <= reg_wdata[5];
        end
        if (!reg_wdata[2]) ctrl_q.pending <= 1'b0;
      end
      if (accept)      ctrl_q.pending <= 1'b0;
      if (req_hit)     ctrl_q.pending <= 1'b1;
      if (term_single) ctrl_q.enable  <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        RA_CAUSE:   reg_rdata <= REG_W'({expand_q, cause_q});
        RA_CTRL:    reg_rdata <= REG_W'(CTRL_W'(ctrl_q));
        RA_SRC:     reg_rdata <= REG_W'(rl_src);
        RA_DST:     reg_rdata <= REG_W'(rl_dst);
        RA_CNT:     reg_rdata <= REG_W'(rl_cnt);
        RA_CUR_SRC: reg_rdata <= REG_W'(cur_src);
        RA_CUR_DST: reg_rdata <= REG_W'(cur_dst);
        default:    reg_rdata <= REG_W'(cur_cnt);
      endcase
    end
  end

  dma_req_select u_sel (
    .clk        (clk),
    .rst        (rst),
    .ext_pin    (ext_pin),
    .cause      (cause_q),
    .expand     (expand_q),
    .soft_trig  (soft_q && (cause_q == CAUSE_W'(1))),
    .periph_req (periph_req),
    .alt_req    (alt_req),
    .req_hit    (req_hit)
  );

  dma_xfer_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .unit8       (ctrl_q.unit8),
    .rpt         (ctrl_q.rpt),
    .src_fwd     (ctrl_q.src_fwd),
    .dst_fwd     (ctrl_q.dst_fwd),
    .ld_src      (wr_src),
    .ld_dst      (wr_dst),
    .ld_cnt      (wr_cnt),
    .ld_addr_val (reg_wdata[ADDR_W-1:0]),
    .ld_cnt_val  (reg_wdata[CNT_W-1:0]),
    .rl_src      (rl_src),
    .rl_dst      (rl_dst),
    .rl_cnt      (rl_cnt),
    .bus_ack     (bus_ack),
    .bus_rdata   (bus_rdata),
    .bus_valid   (bus_valid),
    .bus_we      (bus_we),
    .bus_byte    (bus_byte),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .accept      (accept),
    .term_single (term_single),
    .idle        (eng_idle),
    .cur_src     (cur_src),
    .cur_dst     (cur_dst),
    .cur_cnt     (cur_cnt)
  );
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
`timescale 1ns/1ps
module dma_chan_ctrl_chk
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [2:0]        reg_addr,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              bus_valid,
  input logic              bus_we,
  input logic              bus_ack,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              req_hit,
  input ctrl_t             ctrl,
  input logic [CNT_W-1:0]  cur_cnt
);
  // R7: direction bits never both forward
  a_r7_dirs_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.src_fwd && ctrl.dst_fwd));

  // R5: software trigger bit reads back 0
  a_r5_soft_reads_zero: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == RA_CAUSE) |-> !reg_rdata[5]);

  // R9: a bus access starts only from a pending, enabled channel
  a_r9_start_needs_pending: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_valid) |-> $past(ctrl.pending && ctrl.enable));

  // R9: pending clears once the source read is accepted
  a_r9_pending_clears: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_we && bus_ack && !req_hit) |=> !ctrl.pending);

  // R11: single mode disables at terminal count
  a_r11_single_disables: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_we && bus_ack && !ctrl.rpt && cur_cnt == CNT_W'(1)
     && !(reg_we && reg_addr == RA_CTRL)) |=> !ctrl.enable);

  // R13: request held stable until acknowledged
  a_r13_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_ack   (bus_ack),
  .bus_addr  (bus_addr),
  .req_hit   (req_hit),
  .ctrl      (ctrl_q),
  .cur_cnt   (cur_cnt)
);

// File: tb/dma_chan_ctrl_bench.sv
`timescale 1ns/1ps
module dma_chan_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ext_pin = 1'b1;
  logic [15:2] periph_req = '0;
  logic [1:0]  alt_req = '0;
  logic        bus_valid, bus_we, bus_byte;
  logic [15:0] bus_addr, bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  int n_rd = 0;
  int n_wr = 0;
  logic [15:0] rd_log [0:63];
  logic [15:0] wa_log [0:63];
  logic [15:0] wd_log [0:63];

  always #4 clk = ~clk;

  dma_chan_ctrl u_dma_chan_ctrl (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .periph_req(periph_req), .alt_req(alt_req), .bus_valid(bus_valid),
    .bus_we(bus_we), .bus_byte(bus_byte), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  function automatic logic [15:0] mem_val(input logic [15:0] a, input logic b8);
    logic [15:0] v;
    v = a ^ 16'hA5C3;
    return b8 ? {8'h00, v[7:0]} : v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 v = reg_rdata;
  endtask

  task automatic pend_is(input string tag, input logic exp);
    logic [15:0] v;
    idle(6);
    rd(3'd1, v);
    chk(tag, v[2], exp);
  endtask

  task automatic pulse_p(input int idx);
    @(negedge clk); periph_req[idx] = 1'b1;
    @(negedge clk); periph_req = '0;
  endtask

  task automatic pulse_alt(input int idx);
    @(negedge clk); alt_req[idx] = 1'b1;
    @(negedge clk); alt_req = '0;
  endtask

  task automatic wait_wr(input int n);
    for (int i = 0; i < 300 && n_wr < n; i++) @(negedge clk);
  endtask

  // Bus responder with random acknowledge delay
  initial begin
    int wt;
    wt = 0;
    forever begin
      @(negedge clk);
      bus_ack = 1'b0;
      if (bus_valid) begin
        if (wt == 0) begin
          if (!bus_we) begin
            bus_rdata = mem_val(bus_addr, 1'b0);
            rd_log[n_rd % 64] = bus_addr;
            n_rd++;
          end else begin
            wa_log[n_wr % 64] = bus_addr;
            wd_log[n_wr % 64] = bus_wdata;
            n_wr++;
          end
          bus_ack = 1'b1;
          wt = $urandom % 3;
        end else begin
          wt--;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int base;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, v); chk("R1 cause reset", v, 16'h0000);
    rd(3'd1, v); chk("R1 ctrl reset", v, 16'h0000);
    chk("R1 bus idle", bus_valid, 1'b0);

    // R8 unassigned bits
    wr(3'd0, 16'hFFC3); rd(3'd0, v); chk("R8 cause unassigned", v, 16'h0003);
    wr(3'd1, 16'hFFC0); rd(3'd1, v); chk("R8 ctrl unassigned", v, 16'h0000);

    // R5 software trigger
    wr(3'd0, 16'h0022); pend_is("R5 soft ignored for code 2", 1'b0);
    wr(3'd0, 16'h0021); pend_is("R5 soft sets pending", 1'b1);
    rd(3'd0, v); chk("R5 soft bit reads 0", v, 16'h0001);

    // R6 pending write semantics
    wr(3'd1, 16'h0000); pend_is("R6 write 0 clears", 1'b0);
    wr(3'd1, 16'h0004); pend_is("R6 write 1 no effect", 1'b0);

    // R7 direction exclusion
    wr(3'd1, 16'h0011); rd(3'd1, v); chk("R7 src fwd accepted", v, 16'h0011);
    wr(3'd1, 16'h0032); rd(3'd1, v); chk("R7 both fwd rejected", v, 16'h0012);
    wr(3'd1, 16'h0000);

    // R2 random cause codes and distractor strobes
    for (int i = 0; i < 16; i++) begin
      int code;
      logic [15:0] m;
      code = 2 + ($urandom % 14);
      wr(3'd0, 16'(code));
      wr(3'd1, 16'h0000);
      m = 16'($urandom);
      m[code] = 1'b0;
      @(negedge clk); periph_req = m[15:2]; alt_req = 2'($urandom);
      @(negedge clk); periph_req = '0; alt_req = '0;
      pend_is($sformatf("R2 code %0d distractors", code), 1'b0);
      pulse_p(code);
      pend_is($sformatf("R2 code %0d selected", code), 1'b1);
    end

    // R3 falling edge of pin
    wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
    @(negedge clk); ext_pin = 1'b0;
    pend_is("R3 falling edge", 1'b1);
    wr(3'd1, 16'h0000);
    @(negedge clk); ext_pin = 1'b1;
    pend_is("R3 rising ignored", 1'b0);

    // R4 expanded codes
    wr(3'd0, 16'h0015); wr(3'd1, 16'h0000);
    pulse_p(5); pend_is("R4 periph5 masked", 1'b0);
    pulse_alt(0); pend_is("R4 alt0 selected", 1'b1);
    wr(3'd0, 16'h0016); wr(3'd1, 16'h0000);
    pulse_p(6); pend_is("R4 periph6 masked", 1'b0);
    pulse_alt(1); pend_is("R4 alt1 selected", 1'b1);
    wr(3'd0, 16'h0017); wr(3'd1, 16'h0000);
    @(negedge clk); ext_pin = 1'b0; pend_is("R4 both edges fall", 1'b1);
    wr(3'd1, 16'h0000);
    @(negedge clk); ext_pin = 1'b1; pend_is("R4 both edges rise", 1'b1);

    // R10 R11 single mode, 16-bit, source forward
    wr(3'd0, 16'h0002); wr(3'd1, 16'h0000);
    wr(3'd2, 16'h1000); wr(3'd3, 16'h2000); wr(3'd4, 16'h0003);
    wr(3'd1, 16'h0018);
    base = n_wr;
    for (int t = 0; t < 3; t++) begin
      pulse_p(2);
      wait_wr(base + t + 1);
      chk("R10 read addr", rd_log[(base + t) % 64], 16'h1000 + 16'(2 * t));
      chk("R10 write addr fixed", wa_log[(base + t) % 64], 16'h2000);
      chk("R10 write data", wd_log[(base + t) % 64], mem_val(16'h1000 + 16'(2 * t), 1'b0));
    end
    idle(4);
    rd(3'd1, v); chk("R11 enable cleared", v, 16'h0010);
    rd(3'd7, v); chk("R11 count zero", v, 16'h0000);
    rd(3'd5, v); chk("R10 src advanced", v, 16'h1006);

    // R9 request while disabled is held, no bus activity
    base = n_rd;
    pulse_p(2); idle(10);
    rd(3'd1, v); chk("R9 pending held", v, 16'h0014);
    chk("R9 no access while disabled", n_rd, base);

    // R12 repeat mode, 8-bit, destination forward, starts from held request
    wr(3'd2, 16'h3000); wr(3'd3, 16'h4000); wr(3'd4, 16'h0002);
    base = n_wr;
    wr(3'd1, 16'h002F);
    wait_wr(base + 1);
    chk("R10 byte read addr", rd_log[base % 64], 16'h3000);
    chk("R10 byte write addr", wa_log[base % 64], 16'h4000);
    chk("R10 byte write data", wd_log[base % 64], mem_val(16'h3000, 1'b1));
    pulse_p(2); wait_wr(base + 2);
    chk("R10 byte dst step", wa_log[(base + 1) % 64], 16'h4001);
    idle(4);
    rd(3'd6, v); chk("R12 dst reloaded", v, 16'h4000);
    rd(3'd7, v); chk("R12 count reloaded", v, 16'h0002);
    rd(3'd1, v); chk("R12 stays enabled", v, 16'h002B);
    pulse_p(2); wait_wr(base + 3);
    chk("R12 wrap write addr", wa_log[(base + 2) % 64], 16'h4000);

    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule